// File: doc/BRIEF.md
# Background Tile Row Fetcher

This block produces background pixel rows for a tile-based display. It fetches one 8-pixel row per pass through video memory. Each pass reads the tile index from a tile map, then the low bitplane byte, then the high bitplane byte. It finishes by handing both bytes to a pixel FIFO. The fetcher advances at half the dot rate, so every action is two dots apart and one full row takes eight dots.

A line begins with a single-cycle `lineStart` pulse. That pulse pauses the FIFO, resets the sequence and reloads the fetch column from the horizontal scroll. After a fixed lead-in of idle dots the fetcher starts issuing reads. The control bits choose between two tile maps and between two tile-data addressing schemes:
- an unsigned index from the start of video memory;
- a signed index centred on offset 0x1000.

The first row push releases the FIFO pause. The read port expects a synchronous memory that returns data one cycle after the request.

Top module: `bg_fetcher`

## Requirements
- R1: After reset, `vramRdEn` and `fifoPush` are 0 and `fifoPaused` is 1, and they stay so until `lineStart` is seen.
- R2: A `lineStart` sampled at a clock edge sets `fifoPaused` to 1. The first read request becomes visible right after the seventh following edge: six lead-in dots plus one idle divisor dot.
- R3: Actions of one pass follow a fixed order, each two cycles after the previous one: tile index read, low byte read, high byte read, row push. Passes repeat every 8 cycles. The first push is visible right after the thirteenth edge following `lineStart`. Reads never occur on two consecutive cycles, and a read and a push never share a cycle.
- R4: The tile map base is 0x1800 when `mapSel` is 0 and 0x1C00 when `mapSel` is 1.
- R5: The tile index address is map base + column + ((`lineNum` + `scrollY`) mod 256 / 8) * 32.
- R6: The column starts at (`scrollX` / 8) mod 32 at `lineStart` and advances by one, modulo 32, after each tile index read.
- R7: With `dataSel` = 1, the tile data base is the tile index * 16.
- R8: With `dataSel` = 0, the tile data base is 0x1000 + (tile index read as signed 8-bit) * 16, modulo 2^13.
- R9: The low byte is read at tile data base + ((`lineNum` + `scrollY`) mod 8) * 2 and the high byte at the next address. At the push, `fifoLo` and `fifoHi` carry the bytes returned by those two reads.
- R10: A push clears `fifoPaused`, which then stays 0 until the next `lineStart`.
- R11: A `lineStart` in the same cycle as a pending push or read wins. The push and read strobes are held low in that cycle, the FIFO stays paused, and the line restarts with the R2 timing and the R6 column reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lineStart | input | 1 | Single-cycle pulse opening a new line |
| mapSel | input | 1 | Selects the upper tile map (0x1C00) |
| dataSel | input | 1 | 1: unsigned tile data addressing, 0: signed around 0x1000 |
| scrollX | input | 8 | Horizontal scroll |
| scrollY | input | 8 | Vertical scroll |
| lineNum | input | 8 | Current display line |
| vramData | input | 8 | Read data, valid one cycle after a request |
| vramRdEn | output | 1 | Read request strobe |
| vramAddr | output | 13 | Read address |
| fifoPush | output | 1 | Push one 8-pixel row into the FIFO |
| fifoLo | output | 8 | Low bitplane byte of the pushed row |
| fifoHi | output | 8 | High bitplane byte of the pushed row |
| fifoPaused | output | 1 | FIFO pause flag |

## Verification
The two functions that can meet in one cycle are a line restart and a row push, or a line restart and a read. The bench raises `lineStart` in the very cycle where the first push of a line is showing. It then judges three things:
- both strobes drop at once;
- the pause flag remains set;
- the restarted line repeats the seven- and thirteen-cycle timing with the column reloaded, so the first row fetched again matches the line's first row.

// File: rtl/bgf_pkg.sv
package bgf_pkg;
  localparam int VRAM_AW = 13;
  localparam int BYTE_W  = 8;

  typedef enum logic [1:0] {
    ST_TILE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_PUSH = 2'd3
  } fetchState_e;

  typedef struct packed {
    logic loadLine;
    logic reqTile;
    logic reqLo;
    logic reqHi;
    logic capTile;
    logic capLo;
    logic capHi;
    logic push;
  } fetchStrobe_t;
endpackage

// File: rtl/bgf_ctrl.sv
module bgf_ctrl
  import bgf_pkg::*;
#(
  parameter int LEAD_DOTS = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lineStart,
  output fetchStrobe_t strobe,
  output logic         fifoPaused
);
  localparam int CNT_W = $clog2(LEAD_DOTS + 1);

  logic [CNT_W-1:0] waitCnt;
  logic             running;
  logic             divisor;
  fetchState_e      state;
  logic             capTileQ, capLoQ, capHiQ;
  logic             act;

  // an action fires only on dots where the divisor is already set
  assign act = running & divisor & ~lineStart;

  always_comb begin
    strobe          = '0;
    strobe.loadLine = lineStart;
    strobe.reqTile  = act & (state == ST_TILE);
    strobe.reqLo    = act & (state == ST_LO);
    strobe.reqHi    = act & (state == ST_HI);
    strobe.push     = act & (state == ST_PUSH);
    strobe.capTile  = capTileQ;
    strobe.capLo    = capLoQ;
    strobe.capHi    = capHiQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waitCnt    <= '0;
      running    <= 1'b0;
      divisor    <= 1'b0;
      state      <= ST_TILE;
      fifoPaused <= 1'b1;
      capTileQ   <= 1'b0;
      capLoQ     <= 1'b0;
      capHiQ     <= 1'b0;
    end else if (lineStart) begin
      waitCnt    <= CNT_W'(LEAD_DOTS);
      running    <= 1'b0;
      divisor    <= 1'b0;
      state      <= ST_TILE;
      fifoPaused <= 1'b1;
      capTileQ   <= 1'b0;
      capLoQ     <= 1'b0;
      capHiQ     <= 1'b0;
    end else begin
      capTileQ <= strobe.reqTile;
      capLoQ   <= strobe.reqLo;
      capHiQ   <= strobe.reqHi;
      if (waitCnt != '0) begin
        waitCnt <= waitCnt - 1'b1;
        if (waitCnt == CNT_W'(1)) running <= 1'b1;
      end
      if (running) begin
        divisor <= ~divisor;
        if (divisor) begin
          state <= fetchState_e'(state + 2'd1);
          if (state == ST_PUSH) fifoPaused <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/bgf_datapath.sv
module bgf_datapath
  import bgf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  fetchStrobe_t        strobe,
  input  logic                mapSel,
  input  logic                dataSel,
  input  logic [BYTE_W-1:0]   scrollX,
  input  logic [BYTE_W-1:0]   scrollY,
  input  logic [BYTE_W-1:0]   lineNum,
  input  logic [BYTE_W-1:0]   vramData,
  output logic [VRAM_AW-1:0]  vramAddr,
  output logic [BYTE_W-1:0]   rowLo,
  output logic [BYTE_W-1:0]   rowHi
);
  localparam int COL_W = 5;
  localparam logic [VRAM_AW-1:0] MAP_LO_BASE  = VRAM_AW'('h1800);
  localparam logic [VRAM_AW-1:0] MAP_HI_BASE  = VRAM_AW'('h1C00);
  localparam logic [VRAM_AW-1:0] SIGNED_BASE  = VRAM_AW'('h1000);

  logic [COL_W-1:0]   col;
  logic [BYTE_W-1:0]  tileNum;
  logic [BYTE_W-1:0]  yPos;
  logic [VRAM_AW-1:0] mapAddr, tileBase, rowOff;

  assign yPos    = lineNum + scrollY;
  assign mapAddr = (mapSel ? MAP_HI_BASE : MAP_LO_BASE)
                 + VRAM_AW'({yPos[7:3], col});
  assign tileBase = dataSel ? VRAM_AW'({tileNum, 4'b0000})
                            : SIGNED_BASE + {tileNum[7], tileNum, 4'b0000};
  assign rowOff   = VRAM_AW'({yPos[2:0], strobe.reqHi});
  assign vramAddr = strobe.reqTile ? mapAddr : tileBase + rowOff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col     <= '0;
      tileNum <= '0;
      rowLo   <= '0;
      rowHi   <= '0;
    end else begin
      if (strobe.loadLine)     col <= scrollX[7:3];
      else if (strobe.reqTile) col <= col + 1'b1;
      if (strobe.capTile) tileNum <= vramData;
      if (strobe.capLo)   rowLo   <= vramData;
      if (strobe.capHi)   rowHi   <= vramData;
    end
  end
endmodule

// File: rtl/bg_fetcher.sv
module bg_fetcher
  import bgf_pkg::*;
#(
  parameter int LEAD_DOTS = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lineStart,
  input  logic         mapSel,
  input  logic         dataSel,
  input  logic [7:0]   scrollX,
  input  logic [7:0]   scrollY,
  input  logic [7:0]   lineNum,
  input  logic [7:0]   vramData,
  output logic         vramRdEn,
  output logic [12:0]  vramAddr,
  output logic         fifoPush,
  output logic [7:0]   fifoLo,
  output logic [7:0]   fifoHi,
  output logic         fifoPaused
);
  fetchStrobe_t strobe;

  bgf_ctrl #(.LEAD_DOTS(LEAD_DOTS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .lineStart  (lineStart),
    .strobe     (strobe),
    .fifoPaused (fifoPaused)
  );

  bgf_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .mapSel   (mapSel),
    .dataSel  (dataSel),
    .scrollX  (scrollX),
    .scrollY  (scrollY),
    .lineNum  (lineNum),
    .vramData (vramData),
    .vramAddr (vramAddr),
    .rowLo    (fifoLo),
    .rowHi    (fifoHi)
  );

  assign vramRdEn = strobe.reqTile | strobe.reqLo | strobe.reqHi;
  assign fifoPush = strobe.push;
endmodule

// File: rtl/bgf_checker.sv
module bgf_checker (
  input logic clk,
  input logic rst_n,
  input logic lineStart,
  input logic vramRdEn,
  input logic fifoPush,
  input logic fifoPaused
);
  // R3
  read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vramRdEn |=> !vramRdEn);

  // R3
  read_push_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vramRdEn, fifoPush}));

  // R10
  push_unpause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifoPush |=> !fifoPaused);

  // R10
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifoPaused && !lineStart) |=> !fifoPaused);

  // R2
  restart_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lineStart |=> fifoPaused);

  // R11
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lineStart |-> (!vramRdEn && !fifoPush));
endmodule

bind bg_fetcher bgf_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lineStart  (lineStart),
  .vramRdEn   (vramRdEn),
  .fifoPush   (fifoPush),
  .fifoPaused (fifoPaused)
);

// File: tb/bg_fetcher_bench.sv
`timescale 1ns/1ps
module bg_fetcher_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lineStart = 1'b0;
  logic        mapSel = 1'b0;
  logic        dataSel = 1'b1;
  logic [7:0]  scrollX = '0;
  logic [7:0]  scrollY = '0;
  logic [7:0]  lineNum = '0;
  logic [7:0]  vramData;
  logic        vramRdEn;
  logic [12:0] vramAddr;
  logic        fifoPush;
  logic [7:0]  fifoLo, fifoHi;
  logic        fifoPaused;

  int total = 0;
  int bad = 0;

  // small override table on top of a computed memory image
  int          ovCnt = 0;
  logic [12:0] ovAddr [4];
  logic [7:0]  ovData [4];

  always #10 clk = ~clk;

  bg_fetcher u_bg_fetcher (
    .clk(clk), .rst_n(rst_n), .lineStart(lineStart), .mapSel(mapSel),
    .dataSel(dataSel), .scrollX(scrollX), .scrollY(scrollY), .lineNum(lineNum),
    .vramData(vramData), .vramRdEn(vramRdEn), .vramAddr(vramAddr),
    .fifoPush(fifoPush), .fifoLo(fifoLo), .fifoHi(fifoHi), .fifoPaused(fifoPaused)
  );

  function automatic logic [7:0] memRead(logic [12:0] a);
    for (int i = 0; i < ovCnt; i++)
      if (ovAddr[i] == a) return ovData[i];
    return 8'((int'(a) * 37) ^ (int'(a) >> 4) ^ 8'h5A);
  endfunction

  always_ff @(posedge clk)
    if (vramRdEn) vramData <= memRead(vramAddr);

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int expMapAddr(int n);
    int y = (int'(lineNum) + int'(scrollY)) % 256;
    int col = ((int'(scrollX) / 8) + n) % 32;
    return (mapSel ? 'h1C00 : 'h1800) + col + (y / 8) * 32;
  endfunction

  function automatic int expTileBase(int tile);
    int s = (tile >= 128) ? tile - 256 : tile;
    if (dataSel) return tile * 16;
    return (4096 + s * 16) & 'h1FFF;
  endfunction

  task automatic pulseLine();
    @(negedge clk); lineStart = 1'b1;
    @(negedge clk); lineStart = 1'b0;
  endtask

  // Called right after the edge that sampled lineStart (k = 0).
  task automatic measureLine(string tag, int rows);
    int rdK [48]; int rdA [48]; int nRd = 0;
    int pK [16]; int pLo [16]; int pHi [16]; int nPush = 0;
    int lastK = 13 + 8 * (rows - 1);
    for (int k = 1; k <= lastK; k++) begin
      @(negedge clk);
      chk(fifoPaused == (nPush == 0), {tag, "/R10"}, "pause flag", fifoPaused, nPush == 0);
      if (vramRdEn && nRd < 48) begin rdK[nRd] = k; rdA[nRd] = vramAddr; nRd++; end
      if (fifoPush && nPush < 16) begin
        pK[nPush] = k; pLo[nPush] = fifoLo; pHi[nPush] = fifoHi; nPush++;
      end
    end
    chk(nRd == 3 * rows, {tag, "/R3"}, "read count", nRd, 3 * rows);
    chk(nPush == rows, {tag, "/R3"}, "push count", nPush, rows);
    for (int n = 0; n < rows && nPush == rows && nRd == 3 * rows; n++) begin
      int ma = expMapAddr(n);
      int tb = expTileBase(memRead(13'(ma)));
      int yr = (int'(lineNum) + int'(scrollY)) % 8;
      int la = (tb + yr * 2) & 'h1FFF;
      for (int m = 0; m < 3; m++)
        chk(rdK[3*n+m] == 7 + 8*n + 2*m, {tag, "/R3"}, "read cycle", rdK[3*n+m], 7 + 8*n + 2*m);
      chk(rdA[3*n] == ma, {tag, "/R5"}, "map address", rdA[3*n], ma);
      chk(rdA[3*n+1] == la, {tag, "/R9"}, "low address", rdA[3*n+1], la);
      chk(rdA[3*n+2] == ((la + 1) & 'h1FFF), {tag, "/R9"}, "high address", rdA[3*n+2], (la + 1) & 'h1FFF);
      chk(pK[n] == 13 + 8*n, {tag, "/R3"}, "push cycle", pK[n], 13 + 8*n);
      chk(pLo[n] == memRead(13'(la)), {tag, "/R9"}, "row low", pLo[n], memRead(13'(la)));
      chk(pHi[n] == memRead(13'(la + 1)), {tag, "/R9"}, "row high", pHi[n], memRead(13'(la + 1)));
    end
  endtask

  task automatic testReset();
    chk(vramRdEn == 0, "R1", "read idle", vramRdEn, 0);
    chk(fifoPush == 0, "R1", "push idle", fifoPush, 0);
    chk(fifoPaused == 1, "R1", "paused", fifoPaused, 1);
    repeat (10) @(negedge clk);
    chk(vramRdEn == 0 && fifoPush == 0, "R1", "still idle", {vramRdEn, fifoPush}, 0);
  endtask

  task automatic testTiming();   // R2 R3 R7 R10 with lower map, unsigned data
    mapSel = 0; dataSel = 1; scrollX = 8'h00; scrollY = 8'h03; lineNum = 8'd10;
    pulseLine();
    measureLine("R2/R7", 4);
  endtask

  task automatic testUpperMap();  // R4
    mapSel = 1; dataSel = 1; scrollX = 8'h28; scrollY = 8'h00; lineNum = 8'd77;
    pulseLine();
    measureLine("R4", 3);
  endtask

  task automatic testSigned();    // R8
    ovCnt = 3;
    ovAddr[0] = 13'h1800; ovData[0] = 8'h80;
    ovAddr[1] = 13'h1801; ovData[1] = 8'h7F;
    ovAddr[2] = 13'h1802; ovData[2] = 8'h00;
    mapSel = 0; dataSel = 0; scrollX = 8'h00; scrollY = 8'h00; lineNum = 8'd5;
    pulseLine();
    measureLine("R8", 3);
    ovCnt = 0;
  endtask

  task automatic testColumnWrap(); // R6
    mapSel = 0; dataSel = 1; scrollX = 8'hF3; scrollY = 8'h10; lineNum = 8'd1;
    pulseLine();
    measureLine("R6", 3);
  endtask

  task automatic testLineWrap();   // R5
    mapSel = 1; dataSel = 0; scrollX = 8'h40; scrollY = 8'd100; lineNum = 8'd200;
    pulseLine();
    measureLine("R5", 2);
  endtask

  task automatic testRestart();    // R11
    mapSel = 0; dataSel = 1; scrollX = 8'h18; scrollY = 8'h02; lineNum = 8'd30;
    pulseLine();
    repeat (13) @(negedge clk);
    chk(fifoPush == 1, "R11", "push pending", fifoPush, 1);
    lineStart = 1'b1;
    #1;
    chk(fifoPush == 0, "R11", "push suppressed", fifoPush, 0);
    chk(vramRdEn == 0, "R11", "read suppressed", vramRdEn, 0);
    @(negedge clk); lineStart = 1'b0;
    chk(fifoPaused == 1, "R11", "still paused", fifoPaused, 1);
    measureLine("R11", 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testTiming();
    testUpperMap();
    testSigned();
    testColumnWrap();
    testLineWrap();
    testRestart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule